// File: doc/BRIEF.md
# Macroblock Pixel Supply Sequencer

This block is the producer side of a video encoder's pixel input port. When the encoder raises its request line, the sequencer reads one macroblock of 8-bit samples from a frame-buffer memory through a byte-read port. It puts the samples on a data bus, paced by a one-cycle pixel strobe that is derived from the system clock. One macroblock is a 16x16 luma area plus two 8x8 chroma planes, 384 bytes in all. The bytes go out as six 8x8 sub-blocks in a fixed interleaved order.

The frame-buffer layout is as follows. Luma occupies addresses 0..255, stored row-major with 16 samples per row. The first chroma plane occupies 256..319 and the second occupies 320..383, each stored row-major with 8 samples per row. The read port is combinational. The byte period is `PIX_DIV + IDLE_GAP` system clocks. `PIX_DIV` of at least 2 fixes the fastest strobe rate. `IDLE_GAP` adds spacing so that a lower average rate can be reached, for example one byte every four clocks.

Top module: `mbs_pixel_feeder`

## Requirements
- R1: After reset, `pixStrobe` and `errFlag` are 0.
- R2: Each accepted request produces exactly 384 strobes. A request is accepted when `reqIn` is sampled high while the sequencer is idle.
- R3: Sub-block k (bits [8:6] of the byte position) is sent in order k = 0..5. For k < 4 the sample comes from luma row 8·(k/2)+r and column 8·(k mod 2)+c, that is, from address row·16+col.
- R4: Within a sub-block, sample i (bits [5:0] of the position) has r = i/8 and c = i mod 8. The samples are sent in raster order 0..63.
- R5: Sub-block 4 sample i is read from address 256+i, and sub-block 5 sample i is read from address 320+i.
- R6: The first strobe appears one clock after the request is accepted. Each following strobe comes exactly `PIX_DIV+IDLE_GAP` clocks after the one before, and `PIX_DIV` is at least 2.
- R7: `pixStrobe` is high only in cycles that present a new sample. Between strobes, `pixData` holds the value it had at the last strobe.
- R8: A full macroblock completes within 1871 clocks of its acceptance, because 1+384·(PIX_DIV+IDLE_GAP) ≤ 1871.
- R9: If `reqIn` is sampled low before the 384th byte, the strobes stop at once and `errFlag` rises in the same clock. `errFlag` stays high until the next request is accepted, and that request clears it.
- R10: After a complete macroblock, a request held high starts nothing new. `reqIn` must be sampled low before the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Macroblock request from the encoder, level sensitive |
| rdAddr | output | 9 | Frame-buffer byte address |
| rdData | input | 8 | Frame-buffer read data, combinational from `rdAddr` |
| pixData | output | 8 | Pixel sample bus |
| pixStrobe | output | 1 | One-cycle pixel strobe, high only with valid data |
| errFlag | output | 1 | Sticky error flag, set when a request is withdrawn early |

## Verification
The bench fills the frame buffer with distinct patterns, so any mistake in the quadrant mapping of the luma sub-blocks or in the chroma offsets shows up as a wrong byte. A wrong mapping would deliver, for example, Y2 data where Y3 belongs, or the second chroma plane in place of the first. The reference model predicts every strobe and every sample cycle by cycle. An off-by-one in the phase counter would drift the strobe timing, and a wrong last-byte test would send 383 or 385 bytes. Early request withdrawal is tested right after a start and again mid-block; a design that got it wrong would keep strobing or would miss the error flag. A request held high after completion is tested to catch a design that restarts on a level instead of requiring a fresh request.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int SUB_SIDE   = 8;
  localparam int SUB_COUNT  = 6;
  localparam int SMP_W      = $clog2(SUB_SIDE * SUB_SIDE);
  localparam int SUB_W      = $clog2(SUB_COUNT);
  localparam int POS_W      = SUB_W + SMP_W;
  localparam int MB_BYTES   = SUB_COUNT * SUB_SIDE * SUB_SIDE;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DONE} seqState_e;

  typedef struct packed {
    logic             capture;
    logic [POS_W-1:0] bytePos;
  } seqCtl_t;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int PIX_DIV  = 2,
  parameter int IDLE_GAP = 2,
  parameter int DEADLINE = 1871
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqIn,
  output seqCtl_t ctl,
  output logic    errFlag
);
  localparam int STRIDE = PIX_DIV + IDLE_GAP;
  localparam int PH_W   = $clog2(STRIDE);
  localparam int EL_W   = $clog2(DEADLINE + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(MB_BYTES - 1);

  generate
    if (PIX_DIV < 2) begin : g_badDiv
      $error("PIX_DIV must be at least 2");
    end
    if (1 + MB_BYTES * STRIDE > DEADLINE) begin : g_badRate
      $error("byte period too long for the macroblock deadline");
    end
  endgenerate

  seqState_e        state;
  logic [PH_W-1:0]  phase;
  logic [POS_W-1:0] bytePos;
  logic [EL_W-1:0]  elapsed;
  logic             capture;

  assign capture = (state == ST_SEND) && reqIn && (phase == '0);
  assign ctl.capture = capture;
  assign ctl.bytePos = bytePos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      bytePos <= '0;
      elapsed <= '0;
      errFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqIn) begin
            state   <= ST_SEND;
            phase   <= '0;
            bytePos <= '0;
            elapsed <= '0;
            errFlag <= 1'b0;
          end
        end
        ST_SEND: begin
          elapsed <= elapsed + 1'b1;
          if (!reqIn) begin
            state   <= ST_IDLE;
            errFlag <= 1'b1;
          end else begin
            phase <= (phase == PH_W'(STRIDE - 1)) ? '0 : phase + 1'b1;
            if (phase == '0) begin
              if (bytePos == LAST_POS) state <= ST_DONE;
              else bytePos <= bytePos + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!reqIn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: an early withdrawal ends the transfer and raises the error flag
  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !reqIn) |=> (state == ST_IDLE && errFlag));

  // R10: a request held high after completion does not restart the transfer
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && reqIn) |=> (state == ST_DONE));

  // R2: the last byte moves the sequencer to completion
  a_r2_last_byte_done: assert property (@(posedge clk) disable iff (!rstN)
    (capture && bytePos == LAST_POS) |=> (state == ST_DONE));

  // R8: a transfer never runs past the deadline
  a_r8_deadline: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (elapsed < EL_W'(DEADLINE)));
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  output logic [POS_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pixData,
  output logic              pixStrobe
);
  localparam int ROW_W = $clog2(SUB_SIDE);

  logic [SUB_W-1:0] subIdx;
  logic [SMP_W-1:0] smpIdx;

  assign subIdx = ctl.bytePos[POS_W-1:SMP_W];
  assign smpIdx = ctl.bytePos[SMP_W-1:0];

  // luma quadrant: {0, vertical half, row, horizontal half, col}
  // chroma plane:  {1, plane, sample}
  always_comb begin
    if (!subIdx[2])
      rdAddr = {1'b0, subIdx[1], smpIdx[SMP_W-1:ROW_W], subIdx[0], smpIdx[ROW_W-1:0]};
    else
      rdAddr = {2'b10, subIdx[0], smpIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixData   <= '0;
      pixStrobe <= 1'b0;
    end else begin
      pixStrobe <= ctl.capture;
      if (ctl.capture) pixData <= rdData;
    end
  end

  // R6: strobes are never back to back
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |=> !pixStrobe);

  // R7: data does not move without a strobe
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !pixStrobe |=> (pixStrobe || $stable(pixData)));
endmodule

// File: rtl/mbs_pixel_feeder.sv
module mbs_pixel_feeder
  import mbs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PIX_DIV  = 2,
  parameter int IDLE_GAP = 2,
  parameter int DEADLINE = 1871
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  output logic [8:0]        rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pixData,
  output logic              pixStrobe,
  output logic              errFlag
);
  seqCtl_t ctl;

  mbs_ctrl #(
    .PIX_DIV (PIX_DIV),
    .IDLE_GAP(IDLE_GAP),
    .DEADLINE(DEADLINE)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .ctl    (ctl),
    .errFlag(errFlag)
  );

  mbs_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .pixData  (pixData),
    .pixStrobe(pixStrobe)
  );
endmodule

// File: tb/mbs_pixel_feeder_tb.sv
module mbs_pixel_feeder_tb_top;
  localparam int PIX_DIV  = 2;
  localparam int IDLE_GAP = 2;
  localparam int STRIDE   = PIX_DIV + IDLE_GAP;
  localparam int MB_LEN   = 384;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqIn = 1'b0;
  logic [8:0] rdAddr;
  logic [7:0] rdData;
  logic [7:0] pixData;
  logic       pixStrobe;
  logic       errFlag;
  logic [7:0] fb [0:383];

  always #2 clk = ~clk;
  assign rdData = fb[rdAddr];

  mbs_pixel_feeder #(.PIX_DIV(PIX_DIV), .IDLE_GAP(IDLE_GAP)) dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .rdAddr(rdAddr), .rdData(rdData),
    .pixData(pixData), .pixStrobe(pixStrobe), .errFlag(errFlag)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  function automatic int expAddr(int n);
    int sb = n / 64;
    int i  = n % 64;
    if (sb < 4) return ((sb / 2) * 8 + i / 8) * 16 + (sb % 2) * 8 + (i % 8);
    return 256 + (sb - 4) * 64 + i;
  endfunction

  // behavioural reference model, advanced on each rising edge
  bit mBusy = 0, mDone = 0, mErr = 0, expStb = 0;
  int mN = 0, mWait = 0;
  logic [7:0] expData;

  always @(posedge clk) begin
    expStb = 0;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mErr = 0;
    end else if (mBusy) begin
      if (!reqIn) begin
        mBusy = 0; mErr = 1;
      end else if (mWait == 0) begin
        expStb = 1;
        expData = fb[expAddr(mN)];
        mWait = STRIDE - 1;
        if (mN == MB_LEN - 1) begin mBusy = 0; mDone = 1; end
        else mN++;
      end else mWait--;
    end else if (mDone) begin
      if (!reqIn) mDone = 0;
    end else if (reqIn) begin
      mBusy = 1; mN = 0; mWait = 0; mErr = 0;
    end
  end

  int stbCount = 0;
  bit seenData = 0;
  logic [7:0] lastData;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (pixStrobe !== expStb) begin
        failures++;
        $display("FAIL R6 strobe timing: got %0b expected %0b at %0t", pixStrobe, expStb, $time);
      end
      if (expStb) begin
        checks++;
        if (pixData !== expData) begin
          failures++;
          if (mN < 256 || (mDone && 0))
            $display("FAIL R3/R4 luma sample: got %02h expected %02h", pixData, expData);
          else
            $display("FAIL R5 chroma sample: got %02h expected %02h", pixData, expData);
        end
      end else if (seenData) begin
        checks++;
        if (pixData !== lastData) begin
          failures++;
          $display("FAIL R7 data moved without strobe: got %02h expected %02h", pixData, lastData);
        end
      end
      checks++;
      if (errFlag !== mErr) begin
        failures++;
        $display("FAIL R9 error flag: got %0b expected %0b", errFlag, mErr);
      end
      if (pixStrobe) begin stbCount++; lastData = pixData; seenData = 1; end
    end
  end

  task automatic fill(int seed);
    for (int a = 0; a < 384; a++) fb[a] = 8'((a * 7) ^ (a >> 3) ^ seed);
  endtask

  task automatic checkEq(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic fullBlock(int holdExtra);
    @(negedge clk); stbCount = 0; reqIn = 1;
    repeat (1 + MB_LEN * STRIDE + 2) @(negedge clk);
    checkEq("R2 strobe count per macroblock", stbCount, MB_LEN);
    checkEq("R8 done within deadline", int'(1 + MB_LEN * STRIDE <= 1871), 1);
    stbCount = 0;
    repeat (holdExtra) @(negedge clk);
    checkEq("R10 no restart while request held", stbCount, 0);
    reqIn = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic abortAfter(int cyc, int expStrobes);
    @(negedge clk); stbCount = 0; reqIn = 1;
    repeat (cyc) @(negedge clk);
    reqIn = 0;
    repeat (20) @(negedge clk);
    checkEq("R9 strobes before abort", stbCount, expStrobes);
    checkEq("R9 error flag raised", int'(errFlag), 1);
  endtask

  initial begin
    fill(8'h00);
    repeat (3) @(negedge clk);
    checkEq("R1 strobe low in reset", int'(pixStrobe), 0);
    checkEq("R1 error low in reset", int'(errFlag), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    checkEq("R1 strobe low after reset", int'(pixStrobe), 0);
    fullBlock(40);
    fill(8'h5A);
    fullBlock(5);
    abortAfter(2, 1);
    abortAfter(100, 25);
    fill(8'hC3);
    fullBlock(10);
    checkEq("R9 error cleared by new request", int'(errFlag), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule